// File: doc/BRIEF.md
# Byte-Programmed DMA Command Sequencer

This block is a memory-to-memory DMA controller that software sets up one byte at a time through a single 8-bit write port. Each base byte is classified into a register group by its bit pattern. A base byte can announce follow-on bytes, and the sequencer takes those in a fixed order before it decodes the next base byte. The parsed settings are the port A start address, the block length, the copy direction, and an address step mode for each port. Command bytes reset the whole controller or one port's settings, or start a copy.

A copy moves one byte at a time over a request/grant memory bus. Each byte is a granted read from the source port followed by a granted write to the destination port. Both address counters step after every completed byte. A done flag rises once the programmed number of bytes has moved.

The static input `clone_mode` selects how the enable bit in the third register group is treated. In the strict setting that bit starts a copy at once, even when later setup bytes have not arrived yet. In the clone setting the bit is discarded. The explicit start command works in both settings.

Top module: `dma_cmd_seq`

## Requirements
- R1: Byte 0xC3, written at the base-byte position, resets everything. The start address and length become 0, the direction becomes B-to-A (0), both step modes become hold, the parser returns to base bytes and `xfer_done` clears. A start command issued right after it therefore finishes at once with no bus access.
- R2: Byte 0xC7 sets the port A step mode to hold and byte 0xCB sets the port B step mode to hold. No other setting changes.
- R3: A byte with bit7=0 and bits1:0 not 00 is a group-0 base byte. Bit2 sets the direction (1 = A to B). Bits 3, 4, 5 and 6 each announce one follow-on byte, taken in this order: address low, address high, length low, length high. Only the announced bytes are accepted.
- R4: A byte with bit7=0 and bits2:0=100 sets the port A step mode from bits5:4. A byte with bit7=0 and bits2:0=000 sets the port B step mode from bits5:4. The codes are 00 = decrement, 01 = increment, 10 or 11 = hold.
- R5: With `clone_mode`=0, a byte with bit7=1, bits1:0=00 and bit6=1 starts a copy in the next cycle.
- R6: With `clone_mode`=1, that same byte does not change the transfer state.
- R7: Byte 0x87 starts a copy in both modes. The port A counter is loaded with the start address and the port B counter is loaded with 0. A length of 0 raises `xfer_done` with no bus access. A start command written while a copy is active is ignored.
- R8: Each byte is a read of the source address followed by a write of the read data to the destination address. Each access completes in a cycle where `mem_req` and `mem_gnt` are both high. `mem_addr`, `mem_we` and `mem_wdata` are zero in every other cycle.
- R9: After each completed byte, both counters step by their modes. After exactly `length` bytes, `xfer_active` falls and `xfer_done` rises. `xfer_done` is never high while `xfer_active` is high.
- R10: If 0xC3 is written during a copy, the byte in flight finishes and the copy then stops without raising `xfer_done`.
- R11: Other high-bit base bytes (bits1:0=01, pattern 010, and commands with bits1:0=11 other than those above) leave all settings unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clone_mode | input | 1 | 1 = discard the group-3 enable bit |
| wr_en | input | 1 | Programming byte strobe |
| wr_data | input | 8 | Programming byte |
| mem_req | output | 1 | Memory access request |
| mem_gnt | input | 1 | Memory access grant |
| mem_we | output | 1 | Write strobe (granted cycles only) |
| mem_addr | output | AW | Access address (granted cycles only) |
| mem_wdata | output | 8 | Write data (granted write cycles only) |
| mem_rdata | input | 8 | Read data, taken in the granted read cycle |
| xfer_active | output | 1 | Copy in progress |
| xfer_done | output | 1 | Last copy ran to its full length |

## Verification
The hardest situation to reach is a reset command that lands while a byte is in flight. Reaching it needs a copy that is long enough and a grant that is held high. The stimulus starts a 20-byte copy, polls the write log until a few bytes have landed, and then writes 0xC3. The check confirms that the copy stops short, that `xfer_done` stays low, and that every byte already written is correct. The early start caused by the enable bit is reached by the exact setup sequence in which that bit arrives before the remaining setup bytes, and this sequence is run in both compatibility settings.

// File: rtl/dma_seq_pkg.sv
`timescale 1ns/1ps
package dma_seq_pkg;
  typedef enum logic [2:0] {
    K_NONE, K_WR0, K_WR1, K_WR2, K_WR3, K_WR4, K_WR5, K_WR6
  } base_kind_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} xfer_st_t;

  localparam logic [1:0] STEP_DEC  = 2'b00;
  localparam logic [1:0] STEP_INC  = 2'b01;
  localparam logic [1:0] STEP_HOLD = 2'b10;

  localparam logic [7:0] CMD_RESET_ALL = 8'hC3;
  localparam logic [7:0] CMD_RESET_A   = 8'hC7;
  localparam logic [7:0] CMD_RESET_B   = 8'hCB;
  localparam logic [7:0] CMD_GO        = 8'h87;

  // Classify a byte seen at the base-byte position.
  function automatic base_kind_t classify(input logic [7:0] b);
    if (!b[7]) begin
      if (b[1:0] != 2'b00) return K_WR0;
      else if (b[2])       return K_WR1;
      else                 return K_WR2;
    end else begin
      case (b[1:0])
        2'b00:   return K_WR3;
        2'b01:   return K_WR4;
        2'b11:   return K_WR6;
        default: return b[2] ? K_NONE : K_WR5;
      endcase
    end
  endfunction

  // Index of the lowest announced follow-on byte still owed.
  function automatic logic [1:0] first_pending(input logic [3:0] p);
    if (p[0])      return 2'd0;
    else if (p[1]) return 2'd1;
    else if (p[2]) return 2'd2;
    else           return 2'd3;
  endfunction
endpackage

// File: rtl/dma_cmd_parse.sv
`timescale 1ns/1ps
module dma_cmd_parse
  import dma_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clone_mode,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  output logic [AW-1:0] a_start,
  output logic [LW-1:0] blk_len,
  output logic          dir_a2b,
  output logic [1:0]    a_mode,
  output logic [1:0]    b_mode,
  output logic          start_req,
  output logic          full_reset,
  output logic          wr3_go,
  output logic          at_base
);
  logic [3:0] pend;
  logic       base_wr;
  base_kind_t kind;
  logic [1:0] slot;

  always_comb begin
    at_base    = (pend == 4'b0000);
    kind       = classify(wr_data);
    base_wr    = wr_en && at_base;
    slot       = first_pending(pend);
    full_reset = base_wr && (wr_data == CMD_RESET_ALL);
    wr3_go     = base_wr && (kind == K_WR3) && wr_data[6];
    start_req  = base_wr && ((wr_data == CMD_GO) || (wr3_go && !clone_mode));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= '0;
      a_start <= '0;
      blk_len <= '0;
      dir_a2b <= 1'b0;
      a_mode  <= STEP_HOLD;
      b_mode  <= STEP_HOLD;
    end else if (wr_en) begin
      if (!at_base) begin
        case (slot)
          2'd0:    a_start <= {a_start[AW-1:8], wr_data};
          2'd1:    a_start <= AW'({wr_data, a_start[7:0]});
          2'd2:    blk_len <= {blk_len[LW-1:8], wr_data};
          default: blk_len <= LW'({wr_data, blk_len[7:0]});
        endcase
        pend <= pend & ~(4'b0001 << slot);
      end else begin
        case (kind)
          K_WR0: begin
            dir_a2b <= wr_data[2];
            pend    <= wr_data[6:3];
          end
          K_WR1: a_mode <= wr_data[5:4];
          K_WR2: b_mode <= wr_data[5:4];
          K_WR6: begin
            if (wr_data == CMD_RESET_ALL) begin
              a_start <= '0;
              blk_len <= '0;
              dir_a2b <= 1'b0;
              a_mode  <= STEP_HOLD;
              b_mode  <= STEP_HOLD;
            end else if (wr_data == CMD_RESET_A) begin
              a_mode <= STEP_HOLD;
            end else if (wr_data == CMD_RESET_B) begin
              b_mode <= STEP_HOLD;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_xfer_engine.sv
`timescale 1ns/1ps
module dma_xfer_engine
  import dma_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic          full_reset,
  input  logic [AW-1:0] a_start,
  input  logic [LW-1:0] blk_len,
  input  logic          dir_a2b,
  input  logic [1:0]    a_mode,
  input  logic [1:0]    b_mode,
  output logic          mem_req,
  input  logic          mem_gnt,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          active,
  output logic          done,
  output logic          byte_done
);
  xfer_st_t      st;
  logic [AW-1:0] pa, pb;
  logic [LW-1:0] cnt, len_q;
  logic [DW-1:0] hold;
  logic [1:0]    am_q, bm_q;
  logic          dir_q, abort_q, grant_ok;
  logic [AW-1:0] src_addr, dst_addr;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a, input logic [1:0] m);
    case (m)
      STEP_DEC: return a - 1'b1;
      STEP_INC: return a + 1'b1;
      default:  return a;
    endcase
  endfunction

  function automatic logic is_last(input logic [LW-1:0] c, input logic [LW-1:0] l);
    return (c + 1'b1) == l;
  endfunction

  always_comb begin
    src_addr  = dir_q ? pa : pb;
    dst_addr  = dir_q ? pb : pa;
    mem_req   = ((st == ST_RD) && !abort_q) || (st == ST_WR);
    grant_ok  = mem_req && mem_gnt;
    byte_done = grant_ok && (st == ST_WR);
    mem_addr  = grant_ok ? ((st == ST_WR) ? dst_addr : src_addr) : '0;
    mem_we    = byte_done;
    mem_wdata = byte_done ? hold : '0;
    active    = (st != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      pa      <= '0;
      pb      <= '0;
      cnt     <= '0;
      len_q   <= '0;
      hold    <= '0;
      am_q    <= STEP_HOLD;
      bm_q    <= STEP_HOLD;
      dir_q   <= 1'b0;
      abort_q <= 1'b0;
      done    <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          abort_q <= 1'b0;
          if (start_req) begin
            done <= (blk_len == '0);
            if (blk_len != '0) begin
              pa    <= a_start;
              pb    <= '0;
              cnt   <= '0;
              len_q <= blk_len;
              am_q  <= a_mode;
              bm_q  <= b_mode;
              dir_q <= dir_a2b;
              st    <= ST_RD;
            end
          end
        end
        ST_RD: begin
          if (abort_q) begin
            st <= ST_IDLE;
          end else if (mem_gnt) begin
            hold <= mem_rdata;
            st   <= ST_WR;
          end
        end
        default: begin
          if (mem_gnt) begin
            pa  <= step(pa, am_q);
            pb  <= step(pb, bm_q);
            cnt <= cnt + 1'b1;
            if (abort_q || full_reset) begin
              st <= ST_IDLE;
            end else if (is_last(cnt, len_q)) begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end else begin
              st <= ST_RD;
            end
          end
        end
      endcase
      if (full_reset) begin
        done <= 1'b0;
        if (st != ST_IDLE) abort_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_cmd_seq.sv
`timescale 1ns/1ps
module dma_cmd_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clone_mode,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  output logic          mem_req,
  input  logic          mem_gnt,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          xfer_active,
  output logic          xfer_done
);
  logic [AW-1:0] a_start;
  logic [LW-1:0] blk_len;
  logic          dir_a2b, start_req, full_reset, wr3_go, at_base, byte_done;
  logic [1:0]    a_mode, b_mode;

  dma_cmd_parse #(.AW(AW), .LW(LW)) u_parse (
    .clk(clk), .rst_n(rst_n), .clone_mode(clone_mode),
    .wr_en(wr_en), .wr_data(wr_data),
    .a_start(a_start), .blk_len(blk_len), .dir_a2b(dir_a2b),
    .a_mode(a_mode), .b_mode(b_mode),
    .start_req(start_req), .full_reset(full_reset),
    .wr3_go(wr3_go), .at_base(at_base)
  );

  dma_xfer_engine #(.AW(AW), .LW(LW), .DW(8)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .start_req(start_req), .full_reset(full_reset),
    .a_start(a_start), .blk_len(blk_len), .dir_a2b(dir_a2b),
    .a_mode(a_mode), .b_mode(b_mode),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .active(xfer_active), .done(xfer_done), .byte_done(byte_done)
  );
endmodule

// File: rtl/dma_cmd_seq_chk.sv
`timescale 1ns/1ps
module dma_cmd_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clone_mode,
  input logic          mem_req,
  input logic          mem_gnt,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          xfer_active,
  input logic          xfer_done,
  input logic          full_reset,
  input logic          wr3_go,
  input logic          byte_done
);
  p_bus_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && mem_gnt) |-> (mem_addr == '0 && !mem_we));

  p_write_is_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (byte_done && xfer_active));

  p_wr3_starts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clone_mode && wr3_go && !xfer_active) |=> (xfer_active || xfer_done));

  p_wr3_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clone_mode && wr3_go && !xfer_active) |=> !xfer_active);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !xfer_active);

  p_reset_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    full_reset |=> !xfer_done);
endmodule

bind dma_cmd_seq dma_cmd_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clone_mode(clone_mode),
  .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_addr(mem_addr),
  .xfer_active(xfer_active), .xfer_done(xfer_done),
  .full_reset(full_reset), .wr3_go(wr3_go), .byte_done(byte_done)
);

// File: tb/sim_dma_cmd_seq.sv
`timescale 1ns/1ps
module sim_dma_cmd_seq;
  logic        clk = 1'b0, rst_n = 1'b0, clone_mode = 1'b0, wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        mem_gnt = 1'b0;
  logic        mem_req, mem_we, xfer_active, xfer_done;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  int tests = 0, fails = 0, cyc = 0, log_n = 0, rd_n = 0;
  bit gnt_rand = 1'b0;
  logic [15:0] log_a [0:63];
  logic [7:0]  log_d [0:63];

  dma_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n), .clone_mode(clone_mode),
    .wr_en(wr_en), .wr_data(wr_data),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .xfer_active(xfer_active), .xfer_done(xfer_done)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] pat(input logic [15:0] x);
    return x[7:0] ^ {x[11:8], x[15:12]} ^ 8'hA5;
  endfunction

  function automatic logic [15:0] walk(input logic [15:0] base, input logic [1:0] m, input int i);
    if (m == 2'b01) return base + 16'(i);
    if (m == 2'b00) return base - 16'(i);
    return base;
  endfunction

  assign mem_rdata = pat(mem_addr);

  always @(posedge clk) begin
    cyc++;
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        if (log_n < 64) begin
          log_a[log_n] = mem_addr;
          log_d[log_n] = mem_wdata;
        end
        log_n++;
      end else begin
        rd_n++;
      end
    end
    if (cyc > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(negedge clk) mem_gnt <= gnt_rand ? ($urandom_range(0, 3) != 0) : 1'b1;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic clr_log();
    log_n = 0; rd_n = 0;
  endtask

  task automatic prog(input logic [15:0] a, input logic [15:0] len, input bit dir,
                      input logic [1:0] am, input logic [1:0] bm);
    wr(8'hC3);
    wr(8'h79 | {5'b0, dir, 2'b00});
    wr(a[7:0]); wr(a[15:8]); wr(len[7:0]); wr(len[15:8]);
    wr(8'h04 | {2'b00, am, 4'b0});
    wr(8'h00 | {2'b00, bm, 4'b0});
  endtask

  task automatic wait_idle(input string req);
    int k = 0;
    while (xfer_active && k < 5000) begin @(negedge clk); k++; end
    if (k >= 5000) chk(req, "copy never ended", 1, 0);
  endtask

  task automatic verify(input string req, input logic [15:0] a, input int len, input bit dir,
                        input logic [1:0] am, input logic [1:0] bm);
    int bad = 0;
    wait_idle(req);
    chk(req, "byte count", log_n, len);
    for (int i = 0; i < len && i < 64 && i < log_n; i++) begin
      logic [15:0] s, d;
      s = walk(dir ? a : 16'h0000, dir ? am : bm, i);
      d = walk(dir ? 16'h0000 : a, dir ? bm : am, i);
      if (log_a[i] !== d || log_d[i] !== pat(s)) bad++;
    end
    chk(req, "byte stream mismatches", bad, 0);
    chk(req, "done flag", xfer_done, 1);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "req after reset", mem_req, 0);
    chk("R1", "active after reset", xfer_active, 0);
    chk("R1", "done after reset", xfer_done, 0);

    // R5: strict mode, enable bit fires before the remaining setup bytes
    clone_mode = 1'b0;
    wr(8'hC3); wr(8'hC7); wr(8'hCB);
    wr(8'h7D); wr(8'h21); wr(8'h40); wr(8'h05); wr(8'h00);
    wr(8'h14); wr(8'h10);
    clr_log();
    wr(8'hC0);
    chk("R5", "early start active", xfer_active, 1);
    wr(8'hAD); wr(8'h20); wr(8'h40); wr(8'h82);
    verify("R5", 16'h4021, 5, 1'b1, 2'b01, 2'b01);

    // R6: clone mode, same sequence does nothing until the start command (R7)
    clone_mode = 1'b1;
    prog(16'h4021, 16'd5, 1'b1, 2'b01, 2'b01);
    clr_log();
    wr(8'hC0);
    repeat (3) @(negedge clk);
    chk("R6", "enable bit ignored, active", xfer_active, 0);
    chk("R6", "enable bit ignored, reads", rd_n, 0);
    wr(8'h87);
    verify("R7", 16'h4021, 5, 1'b1, 2'b01, 2'b01);

    // R1 + R7: full reset then start -> zero length, no bus access
    wr(8'hC3);
    chk("R1", "done cleared by reset", xfer_done, 0);
    clr_log();
    wr(8'h87);
    chk("R7", "zero length done", xfer_done, 1);
    chk("R7", "zero length active", xfer_active, 0);
    chk("R1", "zero length reads", rd_n, 0);

    // R2: per-port resets
    clone_mode = 1'b0;
    prog(16'h1200, 16'd4, 1'b1, 2'b01, 2'b01);
    wr(8'hC7);
    clr_log(); wr(8'h87);
    verify("R2", 16'h1200, 4, 1'b1, 2'b10, 2'b01);
    prog(16'h1300, 16'd4, 1'b1, 2'b00, 2'b01);
    wr(8'hCB);
    clr_log(); wr(8'h87);
    verify("R2", 16'h1300, 4, 1'b1, 2'b00, 2'b10);

    // R11: unrelated high-bit base bytes change nothing
    prog(16'h0F00, 16'd6, 1'b0, 2'b00, 2'b01);
    wr(8'hAD); wr(8'hCF); wr(8'h82); wr(8'hB3);
    clr_log(); wr(8'h87);
    // R7: a start command during the copy is ignored
    wr(8'h87);
    verify("R11", 16'h0F00, 6, 1'b0, 2'b00, 2'b01);

    // R3: only the flagged follow-on bytes are taken (address low only, length low only)
    prog(16'h3344, 16'd2, 1'b1, 2'b01, 2'b01);
    wr(8'h2D); wr(8'h99); wr(8'h03);
    clr_log(); wr(8'h87);
    verify("R3", 16'h3399, 3, 1'b1, 2'b01, 2'b01);

    // R10: reset mid-copy
    gnt_rand = 1'b0;
    prog(16'h2000, 16'd20, 1'b1, 2'b01, 2'b01);
    clr_log(); wr(8'h87);
    while (log_n < 3) @(negedge clk);
    wr(8'hC3);
    repeat (4) @(negedge clk);
    chk("R10", "active after abort", xfer_active, 0);
    chk("R10", "done after abort", xfer_done, 0);
    chk("R10", "stopped short", (log_n >= 3 && log_n < 20), 1);
    begin
      int bad = 0;
      for (int i = 0; i < log_n && i < 20; i++)
        if (log_a[i] !== walk(16'h0000, 2'b01, i) || log_d[i] !== pat(walk(16'h2000, 2'b01, i))) bad++;
      chk("R10", "bytes before abort", bad, 0);
    end

    // R8/R9/R4/R3: random programs with random grant
    gnt_rand = 1'b1;
    for (int n = 0; n < 24; n++) begin
      logic [15:0] a;
      int len;
      bit dir;
      logic [1:0] am, bm;
      a = 16'($urandom);
      len = $urandom_range(1, 12);
      dir = 1'($urandom);
      am = 2'($urandom);
      bm = 2'($urandom);
      clone_mode = 1'($urandom);
      prog(a, 16'(len), dir, am, bm);
      clr_log();
      if (clone_mode || $urandom_range(0, 1) == 0) wr(8'h87);
      else wr(8'hC0);
      verify("R9", a, len, dir, am, bm);
      chk("R8", "one read per byte", rd_n, len);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule